// File: doc/BRIEF.md
# SD Bus Sampling-Phase Tuning Sequencer

This block runs the sampling-point search that an SD/eMMC host controller performs before it switches to a fast bus timing. Software writes a self-clearing execute bit. The block then steps a 6-bit phase counter through a fixed number of iterations. For each phase it asks the command engine for one tuning command, receives the tuning block the card returns as a byte stream, and compares that block byte by byte with a reference pattern it computes itself. The result of each phase goes into a pass map.

When the last iteration ends, the block finds the longest run of passing phases. If that run is long enough, the block drives the centre of the run onto the phase-select output, sets a sticky tuned flag and clears the execute bit. If no run is long enough, it clears both bits and selects phase zero, which is the fixed-clock fallback. Software can abort a sweep at any time. An abort pulses a reset request for the command and data paths.

Top module: `sd_tune_seq`

## Requirements
- R1: After synchronous reset, `ctl_exec`, `ctl_tuned`, `cmd_start`, `rd_irq` and `path_reset` are 0, `phase_sel` is 0 and `pass_map` is all zeros.
- R2: A write (`ctl_wr`=1) with `ctl_wr_exec`=1 while idle is accepted when `speed_mode` is 3 (SDR104), 4 (DDR50) or 5 (HS200), or when it is 2 (SDR50) with `sdr50_tune_cap`=1. In the cycle after that write, `ctl_exec` reads 1, `ctl_tuned` reads 0 and `cmd_start` is high with `phase_sel`=0.
- R3: A start write in any other mode leaves `ctl_exec` at 0 and produces no `cmd_start`. The other modes are 0, 1 and 7, mode 6 (HS400), and mode 2 without the capability bit.
- R4: Reference byte i is ((i*37) mod 256) XOR 0x5A. The block length is 128 bytes when `hs200_cmd`=1 and `bus_8bit`=1, and 64 bytes otherwise. A block passes only if exactly that many bytes arrive before `rx_blk_end` and every byte matches.
- R5: Each `rx_blk_end` during a receive phase writes the pass result into bit k of `pass_map`, where k is the phase in use. It also raises `rd_irq` for exactly one cycle, in the cycle after the strobe. `rd_irq` rises at no other time.
- R6: Iteration k (0..39) issues exactly one `cmd_start` cycle with `phase_sel`=k. The next iteration starts in the cycle after the previous block ends, and a sweep has exactly 40 iterations.
- R7: One cycle after the 40th block's `rd_irq`, `ctl_exec` reads 0. If the longest run of consecutive passing phases has length L >= 4 and starts at phase S, then `ctl_tuned`=1 and `phase_sel`=S+floor((L-1)/2). When two runs are equally long, the one with the lower phases wins.
- R8: If the longest run is shorter than 4, the sweep ends with `ctl_exec`=0, `ctl_tuned`=0 and `phase_sel`=0.
- R9: A write with both bits 0 during a sweep is an abort. In the next cycle `ctl_exec`=0, `ctl_tuned`=0, `phase_sel`=0 and `path_reset` is high for one cycle. After the abort, block strobes change neither `pass_map` nor `rd_irq`.
- R10: During a sweep, every write other than an abort is ignored. While idle, a write of exec=0 and tuned=1 leaves `ctl_tuned` unchanged, and a write of both bits 0 clears `ctl_tuned`.
- R11: An accepted start clears `pass_map` and `ctl_tuned` before the first iteration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wr_exec | input | 1 | Execute bit value written |
| ctl_wr_tuned | input | 1 | Tuned bit value written |
| ctl_exec | output | 1 | Execute bit readback (self-clearing) |
| ctl_tuned | output | 1 | Tuned flag readback (sticky) |
| speed_mode | input | 3 | Bus speed mode code |
| sdr50_tune_cap | input | 1 | Tuning requested for SDR50 |
| bus_8bit | input | 1 | 8-bit data bus selected |
| hs200_cmd | input | 1 | HS200 tuning command in use |
| cmd_start | output | 1 | Issue one tuning command |
| rx_valid | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received data byte |
| rx_blk_end | input | 1 | End of received tuning block |
| rd_irq | output | 1 | Buffer-read-ready event, one per block |
| path_reset | output | 1 | Command and data path reset request |
| phase_sel | output | 6 | Sampling phase select |
| pass_map | output | 40 | Per-phase pass results |

## Verification
The bench drives inputs on the falling edge and samples one falling edge after the edge that captures them. `ctl_exec`, `ctl_tuned` and `cmd_start` are therefore checked one cycle after a control write. `rd_irq`, the new `pass_map` bit and the next phase are checked one cycle after `rx_blk_end`. The final `ctl_exec`, `ctl_tuned` and `phase_sel` are checked one cycle later still, because the sweep passes through a one-cycle finish state. Abort effects and ignored writes are read at the ports in the cycle after the write, and then again after further block strobes.

// File: rtl/sd_tune_pkg.sv
package sd_tune_pkg;

    localparam int DEF_PHASE_W  = 6;
    localparam int DEF_ITER_MAX = 40;
    localparam int DEF_MIN_RUN  = 4;
    localparam int LEN_STD      = 64;
    localparam int LEN_WIDE     = 128;
    localparam int CNT_W        = $clog2(LEN_WIDE) + 1;

    typedef enum logic [2:0] {
        SPD_SDR12  = 3'd0,
        SPD_SDR25  = 3'd1,
        SPD_SDR50  = 3'd2,
        SPD_SDR104 = 3'd3,
        SPD_DDR50  = 3'd4,
        SPD_HS200  = 3'd5,
        SPD_HS400  = 3'd6,
        SPD_LEGACY = 3'd7
    } speed_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_RECV,
        ST_FINISH
    } tstate_e;

    typedef struct packed {
        logic done;
        logic pass;
    } blk_res_t;

    // Expected byte of the tuning block at a given index
    function automatic logic [7:0] ref_byte(input logic [CNT_W-1:0] idx);
        logic [15:0] prod;
        prod = 16'(idx) * 16'd37;
        return prod[7:0] ^ 8'h5A;
    endfunction

    // Timing modes that need the sampling point searched
    function automatic logic mode_tunable(input speed_e m, input logic sdr50_cap);
        case (m)
            SPD_SDR104, SPD_DDR50, SPD_HS200: return 1'b1;
            SPD_SDR50:                        return sdr50_cap;
            default:                          return 1'b0;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] pattern_len(input logic wide_bus, input logic hs200);
        return (wide_bus && hs200) ? CNT_W'(LEN_WIDE) : CNT_W'(LEN_STD);
    endfunction

endpackage

// File: rtl/sd_tune_pchk.sv
module sd_tune_pchk
    import sd_tune_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             active,
    input  logic [CNT_W-1:0] len,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             rx_end,
    output blk_res_t         res
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_q;
    logic             mis_q;
    logic             byte_bad;
    logic [CNT_W:0]   cnt_seen;

    // A byte past the expected length is always a mismatch
    assign byte_bad = rx_valid && ((cnt_q >= len_q) || (rx_byte != ref_byte(cnt_q)));
    assign cnt_seen = {1'b0, cnt_q} + (CNT_W+1)'(rx_valid);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            len_q <= CNT_W'(LEN_STD);
            mis_q <= 1'b0;
        end else if (arm) begin
            cnt_q <= '0;
            len_q <= len;
            mis_q <= 1'b0;
        end else if (active && rx_valid) begin
            if (cnt_q != {CNT_W{1'b1}}) begin
                cnt_q <= cnt_q + 1'b1;
            end
            mis_q <= mis_q | byte_bad;
        end
    end

    assign res.done = active && rx_end;
    assign res.pass = !(mis_q || byte_bad) && (cnt_seen == {1'b0, len_q});

    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
        arm |=> (cnt_q == '0) && !mis_q) else $error("arm did not clear block state"); // R4

endmodule

// File: rtl/sd_tune_win.sv
module sd_tune_win
    import sd_tune_pkg::*;
#(
    parameter int PHASE_W  = DEF_PHASE_W,
    parameter int ITER_MAX = DEF_ITER_MAX,
    parameter int MIN_RUN  = DEF_MIN_RUN
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  blk_res_t            res,
    output logic [PHASE_W-1:0]  iter,
    output logic                last,
    output logic [ITER_MAX-1:0] map,
    output logic                ok,
    output logic [PHASE_W-1:0]  centre
);

    localparam int RUN_W = $clog2(ITER_MAX + 1);

    logic [PHASE_W-1:0] iter_q;
    logic [RUN_W-1:0]   cur_run_q, run_nxt, best_len_q, half;
    logic [PHASE_W-1:0] cur_start_q, start_nxt, best_start_q;
    logic               rec;

    assign rec  = res.done;
    assign last = (iter_q == PHASE_W'(ITER_MAX - 1));
    assign iter = iter_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            iter_q <= '0;
        end else if (rec && !last) begin
            iter_q <= iter_q + 1'b1;
        end
    end

    // One pass bit per phase
    for (genvar g = 0; g < ITER_MAX; g++) begin : g_map
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                bit_q <= 1'b0;
            end else if (rec && (iter_q == PHASE_W'(g))) begin
                bit_q <= res.pass;
            end
        end
        assign map[g] = bit_q;
    end

    // Longest passing run, tracked while the sweep progresses
    always_comb begin
        run_nxt   = res.pass ? cur_run_q + 1'b1 : '0;
        start_nxt = (res.pass && (cur_run_q == '0)) ? iter_q : cur_start_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cur_run_q    <= '0;
            cur_start_q  <= '0;
            best_len_q   <= '0;
            best_start_q <= '0;
        end else if (rec) begin
            cur_run_q   <= run_nxt;
            cur_start_q <= start_nxt;
            if (res.pass && (run_nxt > best_len_q)) begin
                best_len_q   <= run_nxt;
                best_start_q <= start_nxt;
            end
        end
    end

    assign half   = (best_len_q == '0) ? '0 : ((best_len_q - 1'b1) >> 1);
    assign ok     = (best_len_q >= RUN_W'(MIN_RUN));
    assign centre = best_start_q + PHASE_W'(half);

    AST_ITER_RANGE: assert property (@(posedge clk) disable iff (rst)
        iter_q < PHASE_W'(ITER_MAX)) else $error("phase counter out of range"); // R6
    AST_MAP_CLR: assert property (@(posedge clk) disable iff (rst)
        clr |=> (map == '0)) else $error("pass map not cleared on start"); // R11
    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
        best_len_q <= RUN_W'(ITER_MAX)) else $error("run longer than sweep"); // R7

endmodule

// File: rtl/sd_tune_ctl.sv
module sd_tune_ctl
    import sd_tune_pkg::*;
#(
    parameter int PHASE_W = DEF_PHASE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic               wr_exec,
    input  logic               wr_tuned,
    input  speed_e             mode,
    input  logic               sdr50_cap,
    input  blk_res_t           res,
    input  logic               last_iter,
    input  logic               win_ok,
    input  logic [PHASE_W-1:0] win_centre,
    output tstate_e            state,
    output logic               exec,
    output logic               tuned,
    output logic               path_reset,
    output logic               rd_irq,
    output logic               run_clr,
    output logic [PHASE_W-1:0] final_phase
);

    tstate_e state_q;
    logic    start_ok;
    logic    abort;
    logic    clear_wr;

    assign clear_wr = wr && !wr_exec && !wr_tuned;
    assign start_ok = wr && wr_exec && (state_q == ST_IDLE) && mode_tunable(mode, sdr50_cap);
    assign abort    = clear_wr && (state_q != ST_IDLE);
    assign run_clr  = start_ok;
    assign state    = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            exec        <= 1'b0;
            tuned       <= 1'b0;
            path_reset  <= 1'b0;
            rd_irq      <= 1'b0;
            final_phase <= '0;
        end else begin
            path_reset <= 1'b0;
            rd_irq     <= 1'b0;
            if (abort) begin
                state_q     <= ST_IDLE;
                exec        <= 1'b0;
                tuned       <= 1'b0;
                final_phase <= '0;
                path_reset  <= 1'b1;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (start_ok) begin
                            state_q     <= ST_ISSUE;
                            exec        <= 1'b1;
                            tuned       <= 1'b0;
                            final_phase <= '0;
                        end else if (clear_wr) begin
                            tuned <= 1'b0;
                        end
                    end
                    ST_ISSUE: state_q <= ST_RECV;
                    ST_RECV: begin
                        if (res.done) begin
                            rd_irq  <= 1'b1;
                            state_q <= last_iter ? ST_FINISH : ST_ISSUE;
                        end
                    end
                    ST_FINISH: begin
                        state_q     <= ST_IDLE;
                        exec        <= 1'b0;
                        tuned       <= win_ok;
                        final_phase <= win_ok ? win_centre : '0;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start_ok |=> exec && !tuned) else $error("start did not arm"); // R2
    AST_REJECT_MODE: assert property (@(posedge clk) disable iff (rst)
        (wr && wr_exec && (state_q == ST_IDLE) && !mode_tunable(mode, sdr50_cap)) |=> !exec)
        else $error("start accepted in untunable mode"); // R3
    AST_IRQ_ONE: assert property (@(posedge clk) disable iff (rst)
        rd_irq |=> !rd_irq) else $error("irq longer than one cycle"); // R5
    AST_FINISH_CLR: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FINISH) |=> !exec) else $error("execute bit not self-cleared"); // R7
    AST_ABORT: assert property (@(posedge clk) disable iff (rst)
        abort |=> !exec && !tuned && path_reset) else $error("abort incomplete"); // R9

endmodule

// File: rtl/sd_tune_seq.sv
module sd_tune_seq
    import sd_tune_pkg::*;
#(
    parameter int PHASE_W  = DEF_PHASE_W,
    parameter int ITER_MAX = DEF_ITER_MAX,
    parameter int MIN_RUN  = DEF_MIN_RUN
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ctl_wr,
    input  logic                ctl_wr_exec,
    input  logic                ctl_wr_tuned,
    output logic                ctl_exec,
    output logic                ctl_tuned,
    input  logic [2:0]          speed_mode,
    input  logic                sdr50_tune_cap,
    input  logic                bus_8bit,
    input  logic                hs200_cmd,
    output logic                cmd_start,
    input  logic                rx_valid,
    input  logic [7:0]          rx_byte,
    input  logic                rx_blk_end,
    output logic                rd_irq,
    output logic                path_reset,
    output logic [PHASE_W-1:0]  phase_sel,
    output logic [ITER_MAX-1:0] pass_map
);

    tstate_e            state;
    blk_res_t           res;
    logic               run_clr;
    logic               last_iter;
    logic               win_ok;
    logic [PHASE_W-1:0] win_centre;
    logic [PHASE_W-1:0] iter;
    logic [PHASE_W-1:0] final_phase;

    sd_tune_ctl #(.PHASE_W(PHASE_W)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .wr          (ctl_wr),
        .wr_exec     (ctl_wr_exec),
        .wr_tuned    (ctl_wr_tuned),
        .mode        (speed_e'(speed_mode)),
        .sdr50_cap   (sdr50_tune_cap),
        .res         (res),
        .last_iter   (last_iter),
        .win_ok      (win_ok),
        .win_centre  (win_centre),
        .state       (state),
        .exec        (ctl_exec),
        .tuned       (ctl_tuned),
        .path_reset  (path_reset),
        .rd_irq      (rd_irq),
        .run_clr     (run_clr),
        .final_phase (final_phase)
    );

    sd_tune_pchk u_pchk (
        .clk      (clk),
        .rst      (rst),
        .arm      (state == ST_ISSUE),
        .active   (state == ST_RECV),
        .len      (pattern_len(bus_8bit, hs200_cmd)),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .rx_end   (rx_blk_end),
        .res      (res)
    );

    sd_tune_win #(
        .PHASE_W  (PHASE_W),
        .ITER_MAX (ITER_MAX),
        .MIN_RUN  (MIN_RUN)
    ) u_win (
        .clk    (clk),
        .rst    (rst),
        .clr    (run_clr),
        .res    (res),
        .iter   (iter),
        .last   (last_iter),
        .map    (pass_map),
        .ok     (win_ok),
        .centre (win_centre)
    );

    assign cmd_start = (state == ST_ISSUE);
    assign phase_sel = (state == ST_IDLE) ? final_phase : iter;

    AST_CMD_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> ctl_exec) else $error("command outside sweep"); // R6
    AST_IRQ_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        rd_irq |-> $past(rx_blk_end)) else $error("irq without block end"); // R5
    AST_FAIL_PHASE: assert property (@(posedge clk) disable iff (rst)
        ($fell(ctl_exec) && !ctl_tuned) |-> (phase_sel == '0)) else $error("fallback phase not zero"); // R8

endmodule

// File: tb/sd_tune_seq_tb.sv
module sd_tune_seq_tb;

    typedef struct packed {
        logic [2:0]  mode;
        logic        cap;
        logic        wide;
        logic        hs;
        logic [39:0] mask;
        logic        acc;
        logic        tuned;
        logic [5:0]  phase;
    } vec_t;

    // mode, cap, 8bit, hs200cmd, pass mask, accepted, tuned, final phase
    localparam vec_t VECS [7] = '{
        '{3'd3, 1'b0, 1'b1, 1'b0, 40'h00000FFC00, 1'b1, 1'b1, 6'd14},
        '{3'd5, 1'b0, 1'b1, 1'b1, 40'h0FC000000F, 1'b1, 1'b1, 6'd32},
        '{3'd4, 1'b0, 1'b0, 1'b0, 40'h00007000E0, 1'b1, 1'b0, 6'd0},
        '{3'd2, 1'b1, 1'b0, 1'b1, 40'hF000000000, 1'b1, 1'b1, 6'd37},
        '{3'd2, 1'b0, 1'b0, 1'b0, 40'h0000000000, 1'b0, 1'b0, 6'd0},
        '{3'd6, 1'b1, 1'b0, 1'b0, 40'h0000000000, 1'b0, 1'b0, 6'd0},
        '{3'd3, 1'b0, 1'b0, 1'b0, 40'h0001F0007C, 1'b1, 1'b1, 6'd4}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 1'b0, ctl_wr_exec = 1'b0, ctl_wr_tuned = 1'b0;
    logic        ctl_exec, ctl_tuned;
    logic [2:0]  speed_mode = 3'd0;
    logic        sdr50_tune_cap = 1'b0, bus_8bit = 1'b0, hs200_cmd = 1'b0;
    logic        cmd_start;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_blk_end = 1'b0;
    logic        rd_irq, path_reset;
    logic [5:0]  phase_sel;
    logic [39:0] pass_map;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    sd_tune_seq u_dut (
        .clk(clk), .rst(rst),
        .ctl_wr(ctl_wr), .ctl_wr_exec(ctl_wr_exec), .ctl_wr_tuned(ctl_wr_tuned),
        .ctl_exec(ctl_exec), .ctl_tuned(ctl_tuned),
        .speed_mode(speed_mode), .sdr50_tune_cap(sdr50_tune_cap),
        .bus_8bit(bus_8bit), .hs200_cmd(hs200_cmd),
        .cmd_start(cmd_start),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_blk_end(rx_blk_end),
        .rd_irq(rd_irq), .path_reset(path_reset),
        .phase_sel(phase_sel), .pass_map(pass_map)
    );

    function automatic logic [7:0] tb_ref(input int i);
        return 8'((i * 37) % 256) ^ 8'h5A;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic ctl_write(input logic e, input logic t);
        ctl_wr = 1'b1; ctl_wr_exec = e; ctl_wr_tuned = t;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_wr_exec = 1'b0; ctl_wr_tuned = 1'b0;
    endtask

    // Sends nbytes bytes; byte at bad_idx is corrupted; returns one cycle after the end strobe edge
    task automatic send_block(input int nbytes, input int bad_idx);
        for (int i = 0; i < nbytes; i++) begin
            rx_valid = 1'b1;
            rx_byte  = tb_ref(i) ^ ((i == bad_idx) ? 8'h01 : 8'h00);
            @(negedge clk);
        end
        rx_valid   = 1'b0;
        rx_blk_end = 1'b1;
        @(negedge clk);
        rx_blk_end = 1'b0;
    endtask

    task automatic run_sweep(input logic [39:0] mask, input int len);
        for (int k = 0; k < 40; k++) begin
            chk("R6", "cmd_start", 64'(cmd_start), 64'd1);
            chk("R6", "phase_sel", 64'(phase_sel), 64'(k));
            @(negedge clk);
            if (mask[k]) begin
                send_block(len, -1);
            end else begin
                case (k % 3)
                    0:       send_block(len, k % len);           // R4 wrong byte
                    1:       send_block(len == 128 ? 64 : len - 1, -1); // R4 short block
                    default: send_block(len + 1, -1);            // R4 extra byte
                endcase
            end
            chk("R5", "rd_irq", 64'(rd_irq), 64'd1);
            chk("R4", "pass bit", 64'(pass_map[k]), 64'(mask[k]));
        end
        chk("R7", "exec during finish", 64'(ctl_exec), 64'd1);
        @(negedge clk);
        chk("R5", "rd_irq one cycle", 64'(rd_irq), 64'd0);
        chk("R7", "exec cleared", 64'(ctl_exec), 64'd0);
        chk("R5", "pass_map", 64'(pass_map), 64'(mask));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "exec", 64'(ctl_exec), 64'd0);
        chk("R1", "tuned", 64'(ctl_tuned), 64'd0);
        chk("R1", "phase_sel", 64'(phase_sel), 64'd0);
        chk("R1", "pass_map", 64'(pass_map), 64'd0);
        chk("R1", "pulses", {61'd0, cmd_start, rd_irq, path_reset}, 64'd0);

        for (int v = 0; v < 7; v++) begin
            speed_mode     = VECS[v].mode;
            sdr50_tune_cap = VECS[v].cap;
            bus_8bit       = VECS[v].wide;
            hs200_cmd      = VECS[v].hs;
            ctl_write(1'b1, 1'b0);
            if (VECS[v].acc) begin
                chk("R2", "exec after start", 64'(ctl_exec), 64'd1);
                chk("R11", "tuned cleared", 64'(ctl_tuned), 64'd0);
                chk("R11", "map cleared", 64'(pass_map), 64'd0);
                run_sweep(VECS[v].mask, (VECS[v].wide && VECS[v].hs) ? 128 : 64);
                if (VECS[v].tuned) begin
                    chk("R7", "tuned", 64'(ctl_tuned), 64'd1);
                    chk("R7", "centre phase", 64'(phase_sel), 64'(VECS[v].phase));
                end else begin
                    chk("R8", "tuned", 64'(ctl_tuned), 64'd0);
                    chk("R8", "fallback phase", 64'(phase_sel), 64'd0);
                end
            end else begin
                chk("R3", "exec rejected", 64'(ctl_exec), 64'd0);
                chk("R3", "no cmd_start", 64'(cmd_start), 64'd0);
                @(negedge clk);
                chk("R3", "still idle", {62'd0, ctl_exec, cmd_start}, 64'd0);
            end
        end

        // R10 idle writes: tuned=1 write ignored, clear write clears the flag
        ctl_write(1'b0, 1'b1);
        chk("R10", "tuned kept", 64'(ctl_tuned), 64'd1);
        ctl_write(1'b0, 1'b0);
        chk("R10", "tuned cleared", 64'(ctl_tuned), 64'd0);

        // Partial sweep, then ignored writes, then abort
        speed_mode = 3'd3; bus_8bit = 1'b0; hs200_cmd = 1'b0;
        ctl_write(1'b1, 1'b0);
        chk("R2", "cmd_start at phase 0", {58'd0, cmd_start, phase_sel}, {58'd0, 1'b1, 6'd0});
        @(negedge clk);
        send_block(64, -1);
        chk("R6", "phase advanced", 64'(phase_sel), 64'd1);
        @(negedge clk);
        ctl_write(1'b1, 1'b1);
        chk("R10", "run write ignored", {62'd0, ctl_exec, ctl_tuned}, 64'd2);
        ctl_write(1'b0, 1'b1);
        chk("R10", "partial clear ignored", {62'd0, ctl_exec, ctl_tuned}, 64'd2);
        ctl_write(1'b0, 1'b0);
        chk("R9", "abort bits", {62'd0, ctl_exec, ctl_tuned}, 64'd0);
        chk("R9", "path_reset", 64'(path_reset), 64'd1);
        chk("R9", "phase zero", 64'(phase_sel), 64'd0);
        @(negedge clk);
        chk("R9", "path_reset pulse", 64'(path_reset), 64'd0);
        send_block(64, -1);
        chk("R9", "no irq after abort", 64'(rd_irq), 64'd0);
        chk("R9", "map frozen", 64'(pass_map), 64'd1);
        chk("R9", "no command", 64'(cmd_start), 64'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule